// File: doc/BRIEF.md
# Three-Step Carry-Free Signed-Digit Adder

This block adds two N-digit numbers written in balanced signed digits (each digit -1, 0 or +1, weight 2^i), producing an (N+2)-digit signed-digit sum. No carry travels more than one position, so the depth of each stage does not grow with N. Every digit is carried on two wires, a negative flag and a positive flag.

The addition runs in three register stages. Stage one forms the sum of each digit pair and splits it into an interim digit in {-2,-1,0} and a transfer bit in {0,1} sent one position up. Stage two adds the incoming transfer, giving a value in {-2..1}. It splits that value into a digit in {0,1} and a transfer in {-1,0}. Stage three adds the second transfer, which restores legal digits in {-1,0,+1}. Because the digit ranges in each stage are kept apart, no stage can produce a value that needs a further carry.

Operands enter through a valid/ready handshake, and the sum leaves through another one. A source holds `in_valid` and its operands until `in_ready` is seen high at a clock edge. A sum is presented with `out_valid` and is held unchanged until the sink raises `out_ready`. Each stage advances when it is empty or when the stage after it is advancing. Bubbles therefore close up under back-pressure, and only a fully stalled pipeline refuses input.

Top module: `sda_add3`

## Requirements
- R1: Digits use the code {neg,pos}: 00 is 0, 01 is +1, 10 is -1. The code 11 never appears on any output digit while `out_valid` is high.
- R2: The value of the sum, Σ (pos_i − neg_i)·2^i over N+2 digits, equals the sum of the two operand values for any legal operands.
- R3: In stage one, a digit-pair sum p ≥ 1 gives transfer 1 and interim digit p−2. A sum p ≤ 0 gives transfer 0 and digit p. The interim digit is held as a magnitude 0..2 and never takes the code 3. This holds in particular when every pair sums to +2.
- R4: In stage two, a value q ≤ −1 gives transfer −1 and digit q+2. A value q ≥ 0 gives transfer 0 and digit q. This holds in particular when every pair sums to −2.
- R5: With `out_ready` high, a sum accepted at one clock edge is shown with `out_valid` after the third edge from acceptance, for any N.
- R6: The sum has N+2 digits. Digit N+1 is never +1, and digit 0 is never −1.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the sum stays stable.
- R8: `in_ready` is low only when `out_valid` is high and `out_ready` is low. With the output stalled, exactly three operand pairs are accepted before `in_ready` falls, and none is lost or repeated.
- R9: A synchronous active-low reset clears every stage: after it, `out_valid` is 0 and `in_ready` is 1.
- R10: With `out_ready` held high, one operand pair is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken |
| a_neg | input | N | Negative flags of operand A |
| a_pos | input | N | Positive flags of operand A |
| b_neg | input | N | Negative flags of operand B |
| b_pos | input | N | Positive flags of operand B |
| out_valid | output | 1 | Sum presented |
| out_ready | input | 1 | Sink takes the sum |
| sum_neg | output | N+2 | Negative flags of the sum |
| sum_pos | output | N+2 | Positive flags of the sum |

## Verification
On every cycle, the assertions check the following: that no interim digit takes the unused magnitude code, that no output digit is 11, and that the top and bottom digits stay within their signs. They also check that a stalled sum is held and that `in_ready` falls only behind a stalled output. Numeric correctness can only be shown by the bench scenarios, which compare the sum against integer addition at two widths. The bench also measures the three-cycle latency, runs the all-+2 and all-−2 digit patterns, and counts the pairs accepted behind a stall.

// File: rtl/sda_pkg.sv
package sda_pkg;
  typedef logic [1:0] sd_code_t;  // {neg,pos}
  localparam sd_code_t SD_ZERO = 2'b00;
  localparam sd_code_t SD_PLUS = 2'b01;
  localparam sd_code_t SD_MINUS = 2'b10;
endpackage

// File: rtl/sda_step1.sv
module sda_step1 #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_in,
  output logic           rdy_up,
  input  logic           rdy_dn,
  input  logic [N-1:0]   a_neg,
  input  logic [N-1:0]   a_pos,
  input  logic [N-1:0]   b_neg,
  input  logic [N-1:0]   b_pos,
  output logic           v_q,
  output logic [2*N-1:0] zmag_q,  // interim digit magnitude, digit = -zmag
  output logic [N-1:0]   tr_q     // tr_q[i]: transfer into position i+1
);
  logic [2*N-1:0] zmag_n;
  logic [N-1:0]   tr_n;

  for (genvar i = 0; i < N; i++) begin : g_dig
    logic [2:0] p;
    logic [1:0] zm;
    logic       t;
    always_comb begin
      p = 3'(a_pos[i]) + 3'(b_pos[i]) - 3'(a_neg[i]) - 3'(b_neg[i]);
      case (p)
        3'b010:  begin t = 1'b1; zm = 2'd0; end  // +2 -> t=1, z=0
        3'b001:  begin t = 1'b1; zm = 2'd1; end  // +1 -> t=1, z=-1
        3'b111:  begin t = 1'b0; zm = 2'd1; end  // -1 -> z=-1
        3'b110:  begin t = 1'b0; zm = 2'd2; end  // -2 -> z=-2
        default: begin t = 1'b0; zm = 2'd0; end
      endcase
    end
    assign zmag_n[2*i+:2] = zm;
    assign tr_n[i]        = t;

    assert_zmag_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      v_q |-> zmag_q[2*i+:2] != 2'b11);
  end

  assign rdy_up = !v_q || rdy_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else if (rdy_up) begin
      v_q <= v_in;
      if (v_in) begin
        zmag_q <= zmag_n;
        tr_q   <= tr_n;
      end
    end
  end
endmodule

// File: rtl/sda_step2.sv
module sda_step2 #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_in,
  output logic           rdy_up,
  input  logic           rdy_dn,
  input  logic [2*N-1:0] zmag,
  input  logic [N-1:0]   tr,
  output logic           v_q,
  output logic [N:0]     zp_q,  // digit in {0,1}
  output logic [N:0]     tn_q   // tn_q[i]: transfer -1 into position i+1
);
  logic [N:0] zp_n, tn_n;

  for (genvar i = 0; i <= N; i++) begin : g_pos
    logic [1:0] zm;
    logic       tin;
    logic [2:0] q;
    if (i < N) begin : g_z
      assign zm = zmag[2*i+:2];
    end else begin : g_ztop
      assign zm = 2'd0;
    end
    if (i > 0) begin : g_t
      assign tin = tr[i-1];
    end else begin : g_t0
      assign tin = 1'b0;
    end
    always_comb begin
      q = 3'(tin) - 3'(zm);
      case (q)
        3'b001:  begin tn_n[i] = 1'b0; zp_n[i] = 1'b1; end  // +1
        3'b111:  begin tn_n[i] = 1'b1; zp_n[i] = 1'b1; end  // -1 -> -2+1
        3'b110:  begin tn_n[i] = 1'b1; zp_n[i] = 1'b0; end  // -2 -> -2+0
        default: begin tn_n[i] = 1'b0; zp_n[i] = 1'b0; end  // 0
      endcase
    end
  end

  assign rdy_up = !v_q || rdy_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else if (rdy_up) begin
      v_q <= v_in;
      if (v_in) begin
        zp_q <= zp_n;
        tn_q <= tn_n;
      end
    end
  end
endmodule

// File: rtl/sda_step3.sv
module sda_step3
  import sda_pkg::*;
#(
  parameter int N = 8,
  localparam int W = N + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  output logic         rdy_up,
  input  logic         rdy_dn,
  input  logic [N:0]   zp,
  input  logic [N:0]   tn,
  output logic         v_q,
  output logic [W-1:0] s_neg_q,
  output logic [W-1:0] s_pos_q
);
  logic [W-1:0] s_neg_n, s_pos_n;

  for (genvar i = 0; i < W; i++) begin : g_out
    logic     zd, td;
    sd_code_t c;
    if (i <= N) begin : g_z
      assign zd = zp[i];
    end else begin : g_ztop
      assign zd = 1'b0;
    end
    if (i > 0) begin : g_t
      assign td = tn[i-1];
    end else begin : g_t0
      assign td = 1'b0;
    end
    always_comb begin
      if (zd && !td)      c = SD_PLUS;
      else if (!zd && td) c = SD_MINUS;
      else                c = SD_ZERO;
    end
    assign s_neg_n[i] = c[1];
    assign s_pos_n[i] = c[0];
  end

  assign rdy_up = !v_q || rdy_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else if (rdy_up) begin
      v_q <= v_in;
      if (v_in) begin
        s_neg_q <= s_neg_n;
        s_pos_q <= s_pos_n;
      end
    end
  end

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> (s_neg_q & s_pos_q) == '0);
  assert_edge_digits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> (!s_pos_q[W-1] && !s_neg_q[0]));
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    v_q && !rdy_dn |=> v_q && $stable(s_neg_q) && $stable(s_pos_q));
endmodule

// File: rtl/sda_add3.sv
module sda_add3 #(
  parameter int N = 8,
  localparam int W = N + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] a_neg,
  input  logic [N-1:0] a_pos,
  input  logic [N-1:0] b_neg,
  input  logic [N-1:0] b_pos,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] sum_neg,
  output logic [W-1:0] sum_pos
);
  logic           v1, v2, r2, r3;
  logic [2*N-1:0] zmag;
  logic [N-1:0]   tr;
  logic [N:0]     zp, tn;

  sda_step1 #(.N(N)) u_s1 (
    .clk(clk), .rst_n(rst_n), .v_in(in_valid), .rdy_up(in_ready), .rdy_dn(r2),
    .a_neg(a_neg), .a_pos(a_pos), .b_neg(b_neg), .b_pos(b_pos),
    .v_q(v1), .zmag_q(zmag), .tr_q(tr)
  );

  sda_step2 #(.N(N)) u_s2 (
    .clk(clk), .rst_n(rst_n), .v_in(v1), .rdy_up(r2), .rdy_dn(r3),
    .zmag(zmag), .tr(tr), .v_q(v2), .zp_q(zp), .tn_q(tn)
  );

  sda_step3 #(.N(N)) u_s3 (
    .clk(clk), .rst_n(rst_n), .v_in(v2), .rdy_up(r3), .rdy_dn(out_ready),
    .zp(zp), .tn(tn), .v_q(out_valid), .s_neg_q(sum_neg), .s_pos_q(sum_pos)
  );

  assert_ready_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);
endmodule

// File: tb/sim_sda_add3.sv
module sim_sda_add3;
  localparam int NA = 8;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [NB-1:0] an = '0, ap = '0, bn = '0, bp = '0;
  logic in_ready0, in_ready1, ov0, ov1;
  logic [NA+1:0] sn0, sp0;
  logic [NB+1:0] sn1, sp1;

  sda_add3 #(.N(NA)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready0),
    .a_neg(an[NA-1:0]), .a_pos(ap[NA-1:0]), .b_neg(bn[NA-1:0]), .b_pos(bp[NA-1:0]),
    .out_valid(ov0), .out_ready(out_ready), .sum_neg(sn0), .sum_pos(sp0)
  );
  sda_add3 #(.N(NB)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready1),
    .a_neg(an), .a_pos(ap), .b_neg(bn), .b_pos(bp),
    .out_valid(ov1), .out_ready(out_ready), .sum_neg(sn1), .sum_pos(sp1)
  );

  int checks = 0, fails = 0;
  int q0[$], q1[$];

  function automatic int sdv(input logic [NB+1:0] n, input logic [NB+1:0] p, input int w);
    int v = 0;
    for (int i = 0; i < w; i++) v += (int'(p[i]) - int'(n[i])) * (1 << i);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // mode 0 random legal, 1 all +1, 2 all -1, 3 (-2)+(+2)
  task automatic gen(input int mode);
    for (int i = 0; i < NB; i++) begin
      int ra, rb;
      ra = (mode == 0) ? int'($urandom % 3) : (mode == 1) ? 1 : (mode == 2) ? 2 : 0;
      rb = (mode == 0) ? int'($urandom % 3) : ra;
      ap[i] = (ra == 1); an[i] = (ra == 2);
      bp[i] = (rb == 1); bn[i] = (rb == 2);
    end
    if (mode == 3) begin
      an = 16'h0002; bp = 16'h0004; bn = 16'h0002;
    end
  endtask

  task automatic push();
    q0.push_back(sdv({2'b0, an}, {2'b0, ap}, NA) + sdv({2'b0, bn}, {2'b0, bp}, NA));
    q1.push_back(sdv({2'b0, an}, {2'b0, ap}, NB) + sdv({2'b0, bn}, {2'b0, bp}, NB));
  endtask

  task automatic compare(input string tag);
    int e0, e1, v0, v1;
    e0 = q0.pop_front(); e1 = q1.pop_front();
    v0 = sdv({8'b0, sn0}, {8'b0, sp0}, NA + 2);
    v1 = sdv(sn1, sp1, NB + 2);
    check(v0 == e0, "R2", {tag, " N=8 sum"}, v0, e0);
    check(v1 == e1, "R2", {tag, " N=16 sum"}, v1, e1);
    check(((sn0 & sp0) == '0) && ((sn1 & sp1) == '0), "R1", {tag, " no 11 code"},
          int'(|(sn0 & sp0)) + int'(|(sn1 & sp1)), 0);
    check(!sp0[NA+1] && !sn0[0] && !sp1[NB+1] && !sn1[0], "R6", {tag, " edge digits"},
          int'(sp0[NA+1]) + int'(sn0[0]) + int'(sp1[NB+1]) + int'(sn1[0]), 0);
    check(ov1 == ov0, "R5", {tag, " widths in step"}, int'(ov1), int'(ov0));
  endtask

  task automatic run_stream(input int count, input int mode, input bit throttle,
                            input string tag);
    int sent = 0, stalls = 0;
    bit took = 1'b0;
    while (sent < count || q0.size() > 0) begin
      @(negedge clk);
      if (!in_valid || took) begin
        if (sent < count && (!throttle || ($urandom % 4) != 0)) begin
          gen(mode); in_valid = 1'b1;
        end else in_valid = 1'b0;
      end
      out_ready = throttle ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (ov0 && out_ready) compare(tag);
      if (in_valid && !in_ready0) stalls++;
      took = in_valid && in_ready0;
      if (took) begin push(); sent++; end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    if (!throttle) check(stalls == 0, "R10", {tag, " accept every cycle"}, stalls, 0);
  endtask

  task automatic test_latency();
    int n = 0;
    @(negedge clk);
    gen(3); in_valid = 1'b1; out_ready = 1'b1;
    #1;
    push();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      n++;
      #1;
      if (ov0) break;
    end
    check(n == 3, "R5", "latency cycles", n, 3);
    compare("R5 example");
  endtask

  task automatic fill_stalled(output int acc);
    bit took = 1'b0;
    acc = 0;
    out_ready = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!in_valid || took) begin gen(0); in_valid = 1'b1; end
      #1;
      took = in_valid && in_ready0;
      if (took) begin push(); acc++; end
    end
  endtask

  task automatic test_backpressure();
    int acc;
    logic [NB+1:0] hn, hp;
    fill_stalled(acc);
    check(acc == 3, "R8", "pairs taken behind stall", acc, 3);
    check(!in_ready0 && !in_ready1, "R8", "in_ready low when full", int'(in_ready0), 0);
    @(negedge clk);
    in_valid = 1'b0;
    hn = sn1; hp = sp1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1;
      check(ov0 && ov1 && sn1 == hn && sp1 == hp, "R7", "held under stall",
            int'(sn1 != hn || sp1 != hp), 0);
    end
    run_stream(0, 0, 1'b0, "R8 drain");
  endtask

  task automatic test_reset();
    int acc;
    fill_stalled(acc);
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    #1;
    check(!ov0 && !ov1, "R9", "out_valid cleared by reset", int'(ov0 | ov1), 0);
    check(in_ready0 && in_ready1, "R9", "in_ready after reset", int'(in_ready0 & in_ready1), 1);
    q0.delete(); q1.delete();
    rst_n = 1'b1; out_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!ov0 && !ov1, "R9", "out_valid in reset", int'(ov0 | ov1), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready0 && in_ready1, "R9", "in_ready after reset", int'(in_ready0), 1);
    test_latency();
    run_stream(40, 0, 1'b0, "R2 random");
    run_stream(12, 1, 1'b0, "R3 all pairs +2");
    run_stream(12, 2, 1'b0, "R4 all pairs -2");
    run_stream(200, 0, 1'b1, "R7 throttled");
    test_backpressure();
    test_reset();
    run_stream(30, 0, 1'b0, "R9 after reset");
    summary();
    $finish;
  end
endmodule